// File: doc/BRIEF.md
# Manchester HDLC Frame Transmitter

This block turns a stream of payload bytes into one complete HDLC frame on a single Manchester-coded output line. The frame consists of an alternating training pattern, one opening flag, the payload with zero-bit insertion, a 16-bit CRC, and one closing flag. Bit timing comes from a strobe that pulses at sixteen times the bit rate. One bit period is sixteen strobes. The line sits high whenever no frame is on the wire.

Payload bytes arrive on a valid/ready interface. Back-pressure works as follows. A byte moves only in a cycle where `in_valid` and `in_ready` are both high. The source must hold `in_data` and `in_last` steady while `in_valid` is high and `in_ready` is low. The block buffers exactly one byte ahead of the serializer, so `in_ready` drops for at least one cycle after every accepted byte. Once the byte marked `in_last` has been accepted, `in_ready` stays low until the closing flag has been handed to the line coder.

A frame starts only when three conditions hold: the enable is high, clear-to-send is high, and the first byte is buffered. If the serializer needs another byte and none is buffered, the frame is aborted. `done` marks the moment the line returns to idle, and `done_abort` flags whether that frame was cut short.

Top module: `hdlc_manch_tx`

## Requirements
- R1: After reset, and whenever no frame is being sent, `line_out` is 1, `done` and `done_abort` are 0, and `in_ready` is 1 while nothing is buffered.
- R2: A frame begins only in a cycle where a byte is buffered and both `tx_enable` and `cts` are 1. While either input is 0, the line stays idle and the buffered byte is held (`in_ready` stays 0).
- R3: `tx_enable` and `cts` are examined only when a frame starts. Dropping `cts` during a frame does not change that frame.
- R4: Every frame opens with 16 training bits that alternate, starting with 0 (0,1,0,1,...).
- R5: Exactly one opening flag follows the training bits, and exactly one closing flag ends a completed frame. The flag is the byte 0x7E, which reads 0,1,1,1,1,1,1,0 on the wire.
- R6: Payload bytes are sent in arrival order, each with bit 0 first.
- R7: Within the payload and the CRC, a 0 is inserted after every run of five 1 bits. This includes a run that ends on the last CRC bit, just before the closing flag. No insertion happens in the training bits or the flags.
- R8: The CRC uses polynomial x^16+x^12+x^5+1 with a register preset to 0xFFFF. For each payload bit d in wire order, the update is c = (c<<1) ^ ((c[15]^d) ? 0x1021 : 0). The complement of the final c is sent bits 8..15 first, then bits 0..7.
- R9: Each bit occupies 16 strobes of `tick16`. The line equals the bit value for the first 8 strobes and its complement for the last 8, so a 1 falls at mid-bit and a 0 rises. The line changes only on a clock edge where `tick16` is 1.
- R10: At most one byte is buffered ahead of the serializer. `in_ready` is 0 in the cycle after an accepted byte. Every byte offered is accepted exactly once.
- R11: `done` is a one-cycle pulse, raised in the first cycle that the line is back at idle after the last bit of the frame.
- R12: If the serializer finishes a byte that is not the last one and no further byte is buffered, it sends eight 1 bits without zero insertion and then ends the frame. In that case `done_abort` is 1 together with `done`. Any run of five ones left pending at that point gets no inserted zero.
- R13: A new frame does not start until the line coder has finished the final bit of the previous frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_enable | input | 1 | Allows a new frame to start |
| tick16 | input | 1 | Strobe at sixteen times the bit rate |
| cts | input | 1 | Clear-to-send, checked at frame start |
| in_data | input | DATA_W | Payload byte |
| in_valid | input | 1 | `in_data` holds a byte |
| in_last | input | 1 | This byte ends the frame |
| in_ready | output | 1 | Block will take the byte this cycle |
| line_out | output | 1 | Manchester-coded line, idles high |
| done | output | 1 | Frame finished, one-cycle pulse |
| done_abort | output | 1 | The finishing frame was aborted |

## Verification
The bench aims payloads at runs of ones that cross byte boundaries and reach into the CRC. A design that resets its ones count per byte, or that forgets the stuff bit just before the closing flag, shows up as a bit-stream mismatch. The bench holds `cts` or the enable low with a byte already buffered: a block that ignores either gate starts early, and one that keeps `in_ready` high overwrites the held byte. A frame with a mid-stream underrun must end in eight unstuffed ones with `done_abort` set. A design that inserts a zero into the abort, or that waits for data, fails the stream or timing check. Every frame is decoded half-bit by half-bit, so a swapped Manchester polarity or a 15- or 17-strobe bit is caught even when the bit values are correct.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

  typedef enum logic [2:0] {
    FR_IDLE,
    FR_PREAMBLE,
    FR_OPEN,
    FR_DATA,
    FR_FCS,
    FR_CLOSE,
    FR_ABORT
  } fr_state_e;

  // Flag byte, emitted bit 0 first
  localparam logic [7:0] FLAG_BYTE = 8'h7E;

  // One serial CRC step, data bit d entering at the top
  function automatic logic [15:0] crc16_step(input logic [15:0] c,
                                             input logic        d,
                                             input logic [15:0] poly);
    return {c[14:0], 1'b0} ^ ((c[15] ^ d) ? poly : 16'h0000);
  endfunction

endpackage

// File: rtl/hdlc_tx_crc16.sv
module hdlc_tx_crc16
  import hdlc_tx_pkg::*;
#(
  parameter logic [15:0] POLY = 16'h1021,
  parameter logic [15:0] INIT = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        shift_en,
  input  logic        bit_in,
  output logic [15:0] fcs
);

  logic [15:0] crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        crc_q <= INIT;
    else if (clear)    crc_q <= INIT;
    else if (shift_en) crc_q <= crc16_step(crc_q, bit_in, POLY);
  end

  // Transmitted check sequence is the complemented remainder
  assign fcs = ~crc_q;

endmodule

// File: rtl/hdlc_tx_manch.sv
module hdlc_tx_manch #(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic bit_valid,
  input  logic bit_data,
  output logic bit_take,
  output logic line,
  output logic active,
  output logic done
);

  localparam int PW = $clog2(TICKS_PER_BIT);
  localparam logic [PW-1:0] PH_LAST = PW'(TICKS_PER_BIT - 1);
  localparam logic [PW-1:0] PH_MID  = PW'(TICKS_PER_BIT / 2 - 1);

  logic [PW-1:0] phase_q;
  logic          cur_q;
  logic          at_boundary;

  assign at_boundary = !active || (phase_q == PH_LAST);
  assign bit_take    = tick && at_boundary && bit_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      cur_q   <= 1'b1;
      line    <= 1'b1;
      active  <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        if (at_boundary) begin
          if (bit_valid) begin
            // first half carries the bit value itself
            active  <= 1'b1;
            phase_q <= '0;
            cur_q   <= bit_data;
            line    <= bit_data;
          end else begin
            if (active) done <= 1'b1;
            active <= 1'b0;
            line   <= 1'b1;
          end
        end else begin
          phase_q <= phase_q + 1'b1;
          if (phase_q == PH_MID) line <= ~cur_q;
        end
      end
    end
  end

endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
  import hdlc_tx_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int PREAMBLE_BITS = 16,
  parameter int ABORT_BITS    = 8,
  parameter int STUFF_RUN     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_enable,
  input  logic              cts,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_last,
  output logic              in_ready,
  input  logic              enc_idle,
  input  logic              bit_take,
  output logic              bit_valid,
  output logic              bit_data,
  output logic              crc_clear,
  output logic              crc_en,
  output logic              crc_bit,
  input  logic [15:0]       fcs,
  output logic              busy,
  output logic              aborted
);

  localparam int CW = $clog2(PREAMBLE_BITS + ABORT_BITS + DATA_W + 16);
  localparam int OW = $clog2(STUFF_RUN + 1);
  localparam logic [CW-1:0] PRE_END   = CW'(PREAMBLE_BITS - 1);
  localparam logic [CW-1:0] ABORT_END = CW'(ABORT_BITS - 1);
  localparam logic [CW-1:0] BYTE_END  = CW'(DATA_W - 1);
  localparam logic [CW-1:0] FLAG_END  = CW'(7);
  localparam logic [CW-1:0] FCS_END   = CW'(15);
  localparam logic [OW-1:0] RUN_LAST  = OW'(STUFF_RUN - 1);

  fr_state_e         state_q;
  logic [CW-1:0]     cnt_q;
  logic [DATA_W-1:0] sh_q;
  logic              sh_last_q;
  logic [DATA_W-1:0] hold_q;
  logic              hold_full_q;
  logic              hold_last_q;
  logic              eof_seen_q;
  logic [OW-1:0]     ones_q;
  logic              stuff_q;
  logic              start;
  logic              accept;
  logic              stuffed_state;
  logic [3:0]        fcs_idx;

  assign in_ready      = !hold_full_q && !eof_seen_q;
  assign accept        = in_valid && in_ready;
  assign start         = (state_q == FR_IDLE) && tx_enable && cts && hold_full_q && enc_idle;
  assign bit_valid     = (state_q != FR_IDLE);
  assign busy          = (state_q != FR_IDLE);
  assign crc_clear     = start;
  assign crc_en        = bit_take && (state_q == FR_DATA) && !stuff_q;
  assign crc_bit       = sh_q[0];
  assign stuffed_state = (state_q == FR_DATA) || (state_q == FR_FCS);
  // check byte order: remainder bits 8..15, then 0..7
  assign fcs_idx       = {~cnt_q[3], cnt_q[2:0]};

  always_comb begin
    bit_data = 1'b1;
    if (stuff_q) begin
      bit_data = 1'b0;
    end else begin
      unique case (state_q)
        FR_PREAMBLE:       bit_data = cnt_q[0];
        FR_OPEN, FR_CLOSE: bit_data = FLAG_BYTE[cnt_q[2:0]];
        FR_DATA:           bit_data = sh_q[0];
        FR_FCS:            bit_data = fcs[fcs_idx];
        default:           bit_data = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= FR_IDLE;
      cnt_q       <= '0;
      sh_q        <= '0;
      sh_last_q   <= 1'b0;
      hold_q      <= '0;
      hold_full_q <= 1'b0;
      hold_last_q <= 1'b0;
      eof_seen_q  <= 1'b0;
      ones_q      <= '0;
      stuff_q     <= 1'b0;
      aborted     <= 1'b0;
    end else begin
      if (accept) begin
        hold_q      <= in_data;
        hold_last_q <= in_last;
        hold_full_q <= 1'b1;
        if (in_last) eof_seen_q <= 1'b1;
      end

      if (state_q == FR_IDLE) begin
        if (start) begin
          state_q <= FR_PREAMBLE;
          cnt_q   <= '0;
          ones_q  <= '0;
          stuff_q <= 1'b0;
          aborted <= 1'b0;
        end
      end else if (bit_take) begin
        if (stuff_q) begin
          stuff_q <= 1'b0;
          ones_q  <= '0;
        end else begin
          if (stuffed_state) begin
            if (bit_data) begin
              if (ones_q == RUN_LAST) begin
                stuff_q <= 1'b1;
                ones_q  <= '0;
              end else begin
                ones_q <= ones_q + 1'b1;
              end
            end else begin
              ones_q <= '0;
            end
          end
          cnt_q <= cnt_q + 1'b1;
          unique case (state_q)
            FR_PREAMBLE: begin
              if (cnt_q == PRE_END) begin
                state_q <= FR_OPEN;
                cnt_q   <= '0;
              end
            end
            FR_OPEN: begin
              if (cnt_q == FLAG_END) begin
                state_q     <= FR_DATA;
                cnt_q       <= '0;
                ones_q      <= '0;
                sh_q        <= hold_q;
                sh_last_q   <= hold_last_q;
                hold_full_q <= 1'b0;
              end
            end
            FR_DATA: begin
              sh_q <= sh_q >> 1;
              if (cnt_q == BYTE_END) begin
                cnt_q <= '0;
                if (sh_last_q) begin
                  state_q <= FR_FCS;
                end else if (hold_full_q) begin
                  sh_q        <= hold_q;
                  sh_last_q   <= hold_last_q;
                  hold_full_q <= 1'b0;
                end else begin
                  state_q <= FR_ABORT;
                  aborted <= 1'b1;
                  stuff_q <= 1'b0;
                end
              end
            end
            FR_FCS: begin
              if (cnt_q == FCS_END) begin
                state_q <= FR_CLOSE;
                cnt_q   <= '0;
              end
            end
            FR_CLOSE: begin
              if (cnt_q == FLAG_END) begin
                state_q    <= FR_IDLE;
                eof_seen_q <= 1'b0;
              end
            end
            FR_ABORT: begin
              if (cnt_q == ABORT_END) state_q <= FR_IDLE;
            end
            default: state_q <= FR_IDLE;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/hdlc_manch_tx.sv
module hdlc_manch_tx
  import hdlc_tx_pkg::*;
#(
  parameter int          DATA_W        = 8,
  parameter int          TICKS_PER_BIT = 16,
  parameter int          PREAMBLE_BITS = 16,
  parameter int          ABORT_BITS    = 8,
  parameter int          STUFF_RUN     = 5,
  parameter logic [15:0] CRC_POLY      = 16'h1021,
  parameter logic [15:0] CRC_INIT      = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_enable,
  input  logic              tick16,
  input  logic              cts,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_last,
  output logic              in_ready,
  output logic              line_out,
  output logic              done,
  output logic              done_abort
);

  logic        bit_valid;
  logic        bit_data;
  logic        bit_take;
  logic        enc_active;
  logic        enc_done;
  logic        crc_clear;
  logic        crc_en;
  logic        crc_bit;
  logic [15:0] fcs;
  logic        fr_busy;
  logic        fr_aborted;

  hdlc_tx_framer #(
    .DATA_W        (DATA_W),
    .PREAMBLE_BITS (PREAMBLE_BITS),
    .ABORT_BITS    (ABORT_BITS),
    .STUFF_RUN     (STUFF_RUN)
  ) i_framer (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_enable (tx_enable),
    .cts       (cts),
    .in_data   (in_data),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .in_ready  (in_ready),
    .enc_idle  (!enc_active),
    .bit_take  (bit_take),
    .bit_valid (bit_valid),
    .bit_data  (bit_data),
    .crc_clear (crc_clear),
    .crc_en    (crc_en),
    .crc_bit   (crc_bit),
    .fcs       (fcs),
    .busy      (fr_busy),
    .aborted   (fr_aborted)
  );

  hdlc_tx_crc16 #(
    .POLY (CRC_POLY),
    .INIT (CRC_INIT)
  ) i_crc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (crc_clear),
    .shift_en (crc_en),
    .bit_in   (crc_bit),
    .fcs      (fcs)
  );

  hdlc_tx_manch #(
    .TICKS_PER_BIT (TICKS_PER_BIT)
  ) i_manch (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick16),
    .bit_valid (bit_valid),
    .bit_data  (bit_data),
    .bit_take  (bit_take),
    .line      (line_out),
    .active    (enc_active),
    .done      (enc_done)
  );

  assign done       = enc_done;
  assign done_abort = enc_done && fr_aborted;

endmodule

// File: rtl/hdlc_manch_tx_chk.sv
module hdlc_manch_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic tick16,
  input logic tx_enable,
  input logic cts,
  input logic in_valid,
  input logic in_ready,
  input logic line_out,
  input logic done,
  input logic done_abort,
  input logic fr_busy,
  input logic enc_active
);

  // R2
  start_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fr_busy) |-> $past(tx_enable && cts));

  // R9
  line_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick16 |=> $stable(line_out));

  // R10
  one_byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R1
  idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> line_out);

  // R12
  abort_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_abort |-> done);

  // R13
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fr_busy) |-> !enc_active);

endmodule

bind hdlc_manch_tx hdlc_manch_tx_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick16     (tick16),
  .tx_enable  (tx_enable),
  .cts        (cts),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .line_out   (line_out),
  .done       (done),
  .done_abort (done_abort),
  .fr_busy    (fr_busy),
  .enc_active (enc_active)
);

// File: tb/test_hdlc_manch_tx.sv
module test_hdlc_manch_tx;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tx_enable;
  logic       tick16;
  logic       cts;
  logic [7:0] in_data;
  logic       in_valid;
  logic       in_last;
  logic       in_ready;
  logic       line_out;
  logic       done;
  logic       done_abort;

  always #5 clk = ~clk;

  hdlc_manch_tx i_hdlc_manch_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_enable  (tx_enable),
    .tick16     (tick16),
    .cts        (cts),
    .in_data    (in_data),
    .in_valid   (in_valid),
    .in_last    (in_last),
    .in_ready   (in_ready),
    .line_out   (line_out),
    .done       (done),
    .done_abort (done_abort)
  );

  int   n_chk  = 0;
  int   n_fail = 0;
  int   cyc    = 0;
  logic [7:0] pay [0:15];
  bit   exp_q [$];
  bit   smp   [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    if (cyc == 190000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      report();
      $finish;
    end
  end

  // Expected wire bits from the requirements (R4..R8, R12)
  function automatic void build_exp(input int nb, input bit full);
    bit         raw [$];
    logic [15:0] c = 16'hFFFF;
    int         ones = 0;
    exp_q.delete();
    for (int i = 0; i < 16; i++) exp_q.push_back(bit'(i % 2));
    for (int i = 0; i < 8; i++) exp_q.push_back(bit'(i != 0 && i != 7));
    for (int b = 0; b < nb; b++)
      for (int k = 0; k < 8; k++) begin
        bit d = pay[b][k];
        raw.push_back(d);
        c = {c[14:0], 1'b0} ^ ((c[15] ^ d) ? 16'h1021 : 16'h0000);
      end
    if (full)
      for (int k = 0; k < 16; k++) raw.push_back(~c[k < 8 ? k + 8 : k - 8]);
    for (int i = 0; i < raw.size(); i++) begin
      exp_q.push_back(raw[i]);
      if (raw[i]) begin
        ones++;
        if (ones == 5) begin
          ones = 0;
          if (full || i < raw.size() - 1) exp_q.push_back(1'b0);
        end
      end else ones = 0;
    end
    for (int i = 0; i < 8; i++) exp_q.push_back(full ? bit'(i != 0 && i != 7) : 1'b1);
  endfunction

  task automatic run_frame(input int n, input int nfed, input int tmode, input int vpct,
                           input int cts_wait, input int en_wait, input bit cts_drop,
                           input string tag);
    int idx = 0, acc = 0, t0, rel;
    bit started = 0, fin = 0, tickd = 0, hs = 0, early = 0, bad_rdy = 0, man_ok = 1, dab = 0;
    int done_idx = -1, done_cnt = 0, ng, mis = -1;
    build_exp(nfed, nfed == n);
    smp.delete();
    t0 = cyc;
    in_valid = 0;
    while (!fin && (cyc - t0) < 60000) begin
      @(negedge clk);
      rel = cyc - t0;
      if (done) begin
        done_cnt++;
        if (done_abort) dab = 1;
      end
      if (tickd) begin
        if (!started && line_out == 1'b0) begin
          started = 1;
          if (rel <= cts_wait || rel <= en_wait) early = 1;
        end
        if (started) begin
          if (done) done_idx = smp.size();
          smp.push_back(line_out);
          if (smp.size() % 16 == 0) begin
            bit all1 = 1;
            for (int j = smp.size() - 16; j < smp.size(); j++) if (!smp[j]) all1 = 0;
            if (all1) fin = 1;
          end
        end
      end
      if (acc >= 1 && rel < cts_wait && in_ready) bad_rdy = 1;
      if (acc >= 1 && rel < en_wait && in_ready) bad_rdy = 1;
      cts       = (rel >= cts_wait) && !(cts_drop && started);
      tx_enable = (rel >= en_wait);
      tick16    = (tmode == 0) ? 1'b1 : ($urandom % 3 == 0);
      tickd     = tick16;
      if (hs) in_valid = 0;
      if (!in_valid && idx < nfed && ($urandom % 100) < vpct) begin
        in_valid = 1;
        in_data  = pay[idx];
        in_last  = (idx == n - 1);
      end
      hs = in_valid && in_ready;
      if (hs) begin
        idx++;
        acc++;
      end
    end
    in_valid = 0;
    cts      = 1;
    chk(fin, "R11", {tag, " frame finished"}, fin, 1);
    chk(!early, "R2", {tag, " start after gate release"}, early, 0);
    chk(!bad_rdy, "R10", {tag, " ready low while byte held"}, bad_rdy, 0);
    chk(acc == nfed, "R10", {tag, " bytes accepted"}, acc, nfed);
    ng = (smp.size() / 16) - 1;
    for (int g = 0; g < ng; g++) begin
      bit v = smp[g * 16];
      for (int j = 0; j < 8; j++) begin
        if (smp[g * 16 + j] != v) man_ok = 0;
        if (smp[g * 16 + 8 + j] != ~v) man_ok = 0;
      end
    end
    chk(man_ok, "R9", {tag, " half-bit levels"}, man_ok, 1);
    chk(ng == exp_q.size(), "R5", {tag, " bit count"}, ng, exp_q.size());
    for (int g = 0; g < ng && g < exp_q.size(); g++)
      if (mis < 0 && smp[g * 16] != exp_q[g]) mis = g;
    chk(mis < 0, mis < 16 ? "R4" : (mis < 24 ? "R5" : "R6/R7/R8"),
        {tag, " first wrong bit index"}, mis, -1);
    chk(done_cnt == 1 && done_idx == 16 * ng, "R11 R13", {tag, " done position"},
        done_idx, 16 * ng);
    chk(dab == (nfed != n), "R12", {tag, " abort flag"}, dab, nfed != n);
  endtask

  initial begin
    void'($urandom(32'd4711));
    rst_n = 0; tx_enable = 0; tick16 = 0; cts = 0;
    in_data = 0; in_valid = 0; in_last = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(line_out == 1'b1, "R1", "line idle", line_out, 1);
    chk(done == 1'b0 && done_abort == 1'b0, "R1", "done low", done, 0);
    chk(in_ready == 1'b1, "R1", "ready when empty", in_ready, 1);

    // stuff run inside one byte, reaching the CRC
    pay[0] = 8'hFF;
    run_frame(1, 1, 0, 100, 0, 0, 0, "R7 all-ones");
    // run across a byte boundary and flag-like payload
    pay[0] = 8'h00; pay[1] = 8'h7E; pay[2] = 8'hF8; pay[3] = 8'h1F;
    run_frame(4, 4, 1, 60, 0, 0, 0, "R6 R7 boundary");
    // clear-to-send held off with byte buffered
    pay[0] = 8'hA5; pay[1] = 8'h3C;
    run_frame(2, 2, 0, 100, 400, 0, 0, "R2 cts wait");
    // enable held off
    pay[0] = 8'h5A;
    run_frame(1, 1, 1, 100, 0, 300, 0, "R2 enable wait");
    // cts dropped mid-frame
    pay[0] = 8'h12; pay[1] = 8'h34; pay[2] = 8'h56;
    run_frame(3, 3, 0, 100, 0, 0, 1, "R3 cts drop");
    // underrun: five-byte frame, only two supplied
    pay[0] = 8'h0F; pay[1] = 8'hF0;
    run_frame(5, 2, 0, 100, 0, 0, 0, "R12 underrun");
    // recovery after abort
    pay[0] = 8'hC3; pay[1] = 8'h81;
    run_frame(2, 2, 0, 100, 0, 0, 0, "R12 recovery");
    // random frames, R8 on varied data
    for (int f = 0; f < 8; f++) begin
      int n = 1 + ($urandom % 8);
      for (int b = 0; b < n; b++) pay[b] = 8'($urandom);
      run_frame(n, n, f % 2, 30 + ($urandom % 70), 0, 0, 0, "R8 random");
    end
    report();
    $finish;
  end

endmodule